// File: doc/BRIEF.md
# Synthesizer Programming Sequencer

This block is the host-side master that loads a frequency synthesizer over a three-wire serial port. A clock, a data line and a load enable form the port. On a start strobe it captures:

- a reference divide ratio R,
- a main divide ratio N,
- a prescaler code,
- a configuration payload for the first latch,
- a lock-detect precision bit,
- a charge-pump gain bit.

It splits N into a B count, which is N divided by the prescaler size with the remainder dropped, and a swallow count A, which is that remainder. It checks every range rule. If all rules hold, it sends three words in a fixed order. If any rule fails, it raises an error flag and leaves the port idle.

The serial timing comes from the system clock. Each phase of the serial clock lasts a fixed number of system cycles: the system-clock period divided into the minimum pulse width, rounded up. Each word goes out MSB first, and a load enable pulse follows it. The parameter `WIDE` selects one of two word formats: 21 bits (the default) or 24 bits. The requirements below are stated for the default 21-bit format. In that format the first word uses control code 10 and only prescalers 8 and 32 are accepted.

Top module: `synprog_seq`

## Requirements
- R1: After an accepted start, exactly three words are sent, in this order: the configuration word with control code 10 in bits [1:0] and `cfg_bits` in bits [20:2], then the reference word with code 00, then the main word with code 01.
- R2: Each word is 21 bits long and is shifted MSB first, one bit per rising edge of `sclk`. `sdata` does not change while `sclk` is high.
- R3: B = floor(N/P) and A = N − B·P. The main word carries A in bits [6:2], B in bits [19:7] and `cp_gain` in bit [20].
- R4: The reference word carries R[13:0] in bits [15:2], zeros in bits [19:16] and `ld_prec` in bit [20].
- R5: `pre_sel` selects the prescaler: 00 gives P=8 and 10 gives P=32. Codes 01 and 11 are rejected as a range error.
- R6: A range error is any of the following: R<3, R>16383, B<3, B>8191, A>B, or a rejected prescaler. On a range error, `err` rises, `done` stays low and no `sclk` or `le` edge occurs.
- R7: `sclk` high and low phases each last at least HALF_CYC system cycles, where HALF_CYC = ceil(MIN_HALF_NS/CLK_NS). This is 7 at the defaults.
- R8: `le` stays low while bits are shifted. After the last bit of each word it pulses high for at least HALF_CYC cycles, with `sclk` low throughout the pulse.
- R9: `busy` is high from the cycle after an accepted start until `done` or `err` rises. A start seen while `busy` is high is ignored.
- R10: After reset, `sclk`, `sdata`, `le`, `busy`, `done` and `err` are all 0. An accepted start clears `done` and `err` in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, sampled when idle |
| n_div | input | 19 | Main divide ratio N |
| r_div | input | 16 | Reference divide ratio R |
| pre_sel | input | 2 | Prescaler code |
| cfg_bits | input | 19 | Payload of the configuration word |
| ld_prec | input | 1 | Lock-detect precision bit for the reference word |
| cp_gain | input | 1 | Charge-pump gain bit for the main word |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| le | output | 1 | Load enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| err | output | 1 | Last sequence rejected by a range check |

## Verification
A new start strobe can arrive in the same cycle as the completion of the final word, when `done` rises and `busy` falls. The bench provokes this by raising `start` during the last load enable pulse and holding it until `done` is seen. It then confirms that no further serial clock edge appears, that `done` stays high and that `busy` stays low. A second case sends a start strobe in the middle of a transfer with different inputs. The bench judges that case by the three words that arrive, which must carry only the first inputs.

// File: rtl/synprog_pkg.sv
// Package: shared state types, latch control codes and range limits
// for the synthesizer programming sequencer.
package synprog_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CHECK,
        SQ_SEND
    } seq_state_e;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_TAIL,
        SH_LATCH
    } shift_state_e;

    localparam logic [1:0] CTL_REF  = 2'b00;
    localparam logic [1:0] CTL_MAIN = 2'b01;
    localparam logic [1:0] CTL_FUNC = 2'b10;
    localparam logic [1:0] CTL_INIT = 2'b11;

    localparam int B_W      = 13;
    localparam int RF_W     = 14;
    localparam int R_MIN    = 3;
    localparam int R_MAX    = 16383;
    localparam int B_MIN    = 3;
    localparam int B_MAX    = 8191;
    localparam int WORD_CNT = 3;

    // Half-period in system cycles: ceiling of min width over clock period, at least 1.
    function automatic int half_cycles(input int min_ns, input int clk_ns);
        int q;
        q = (min_ns + clk_ns - 1) / clk_ns;
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/synprog_divsplit.sv
// Module: splits the main ratio N into B (quotient by prescaler) and
// A (remainder), and judges all range rules.
// Assumes: prescaler sizes are powers of two (8,16,32,64 by code),
// so the split is a shift and a mask. In the narrow variant only
// codes 00 (8) and 10 (32) are legal.
module synprog_divsplit
    import synprog_pkg::*;
#(
    parameter bit WIDE  = 1'b0,
    parameter int N_W   = 19,
    parameter int RIN_W = 16,
    localparam int A_W  = WIDE ? 6 : 5
) (
    input  logic [N_W-1:0]   n_i,
    input  logic [1:0]       pre_i,
    input  logic [RIN_W-1:0] r_i,
    output logic [A_W-1:0]   a_o,
    output logic [B_W-1:0]   b_o,
    output logic             ok_o
);

    logic [N_W-1:0] b_full;
    logic [5:0]     a_full;
    logic           pre_ok;

    // Quotient and remainder by shift and mask per prescaler code.
    always_comb begin
        case (pre_i)
            2'd0: begin b_full = n_i >> 3; a_full = {3'b0, n_i[2:0]}; end
            2'd1: begin b_full = n_i >> 4; a_full = {2'b0, n_i[3:0]}; end
            2'd2: begin b_full = n_i >> 5; a_full = {1'b0, n_i[4:0]}; end
            default: begin b_full = n_i >> 6; a_full = n_i[5:0]; end
        endcase
    end

    // Prescaler legality depends on the word variant.
    generate
        if (WIDE) begin : g_pre_wide
            assign pre_ok = 1'b1;
        end else begin : g_pre_narrow
            assign pre_ok = ~pre_i[0];
        end
    endgenerate

    // All range rules combined.
    assign ok_o = pre_ok
                  && (r_i >= RIN_W'(R_MIN)) && (r_i <= RIN_W'(R_MAX))
                  && (b_full >= N_W'(B_MIN)) && (b_full <= N_W'(B_MAX))
                  && (N_W'(a_full) <= b_full);

    assign a_o = a_full[A_W-1:0];
    assign b_o = b_full[B_W-1:0];

    // Recombination check: B*P + A must rebuild N when accepted.
    always_comb begin
        if (ok_o) begin
            assert_split_R3: assert (((N_W'(b_o)) << (3 + int'(pre_i))) + N_W'(a_o) == n_i);
        end
    end

endmodule

// File: rtl/synprog_wordfmt.sv
// Module: assembles one of the three latch words selected by index.
// Assumes: index 0 = first (configuration/initialization) word,
// 1 = reference word, 2 = main word. Control code sits in bits [1:0].
module synprog_wordfmt
    import synprog_pkg::*;
#(
    parameter bit WIDE   = 1'b0,
    localparam int W     = WIDE ? 24 : 21,
    localparam int A_W   = WIDE ? 6 : 5
) (
    input  logic [1:0]      sel_i,
    input  logic [W-3:0]    cfg_i,
    input  logic [RF_W-1:0] r_i,
    input  logic            ld_prec_i,
    input  logic [A_W-1:0]  a_i,
    input  logic [B_W-1:0]  b_i,
    input  logic            gain_i,
    output logic [W-1:0]    word_o
);

    logic [W-1:0] w_first;
    logic [W-1:0] w_ref;
    logic [W-1:0] w_main;

    // Field placement per variant.
    generate
        if (WIDE) begin : g_wide
            assign w_first = {cfg_i, CTL_INIT};
            assign w_ref   = {3'b000, ld_prec_i, 4'b0000, r_i, CTL_REF};
            assign w_main  = {2'b00, gain_i, b_i, a_i, CTL_MAIN};
        end else begin : g_narrow
            assign w_first = {cfg_i, CTL_FUNC};
            assign w_ref   = {ld_prec_i, 4'b0000, r_i, CTL_REF};
            assign w_main  = {gain_i, b_i, a_i, CTL_MAIN};
        end
    endgenerate

    // Pick the word for the current position in the sequence.
    always_comb begin
        case (sel_i)
            2'd0:    word_o = w_first;
            2'd1:    word_o = w_ref;
            default: word_o = w_main;
        endcase
    end

endmodule

// File: rtl/synprog_shifter.sv
// Module: three-wire word engine. On go it shifts one W-bit word MSB
// first, each sclk phase HALF_CYC system cycles long, then holds sclk
// low for one phase, pulses le high for one phase, and pulses fin.
// Assumes: go arrives only while idle.
module synprog_shifter
    import synprog_pkg::*;
#(
    parameter int W        = 21,
    parameter int HALF_CYC = 7,
    localparam int TW      = $clog2(HALF_CYC + 1),
    localparam int CW      = $clog2(W),
    localparam int RW      = $clog2(HALF_CYC + 2) + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] word_i,
    output logic         sclk_o,
    output logic         sdata_o,
    output logic         le_o,
    output logic         fin_o
);

    shift_state_e  state;
    logic [TW-1:0] tmr;
    logic [CW-1:0] bits;
    logic [W-1:0]  sr;

    localparam logic [TW-1:0] RELOAD = TW'(HALF_CYC - 1);

    // Phase sequencing of sclk, sdata and le.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            tmr     <= '0;
            bits    <= '0;
            sr      <= '0;
            sclk_o  <= 1'b0;
            sdata_o <= 1'b0;
            le_o    <= 1'b0;
            fin_o   <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (go_i) begin
                        sr      <= word_i;
                        bits    <= CW'(W - 1);
                        tmr     <= RELOAD;
                        sdata_o <= word_i[W-1];
                        state   <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (tmr == '0) begin
                        sclk_o <= 1'b1;
                        tmr    <= RELOAD;
                        state  <= SH_HIGH;
                    end else begin
                        tmr <= tmr - TW'(1);
                    end
                end
                SH_HIGH: begin
                    if (tmr == '0) begin
                        sclk_o <= 1'b0;
                        tmr    <= RELOAD;
                        if (bits == '0) begin
                            sdata_o <= 1'b0;
                            state   <= SH_TAIL;
                        end else begin
                            bits    <= bits - CW'(1);
                            sr      <= {sr[W-2:0], 1'b0};
                            sdata_o <= sr[W-2];
                            state   <= SH_LOW;
                        end
                    end else begin
                        tmr <= tmr - TW'(1);
                    end
                end
                SH_TAIL: begin
                    if (tmr == '0) begin
                        le_o  <= 1'b1;
                        tmr   <= RELOAD;
                        state <= SH_LATCH;
                    end else begin
                        tmr <= tmr - TW'(1);
                    end
                end
                SH_LATCH: begin
                    if (tmr == '0) begin
                        le_o  <= 1'b0;
                        fin_o <= 1'b1;
                        state <= SH_IDLE;
                    end else begin
                        tmr <= tmr - TW'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // Checker support: run lengths of sclk high, sclk low and le high.
    logic [RW-1:0] hi_run, lo_run, le_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
            le_run <= '0;
        end else begin
            hi_run <= !sclk_o ? '0 : (hi_run == '1 ? hi_run : hi_run + RW'(1));
            lo_run <=  sclk_o ? '0 : (lo_run == '1 ? lo_run : lo_run + RW'(1));
            le_run <= !le_o   ? '0 : (le_run == '1 ? le_run : le_run + RW'(1));
        end
    end

    assert_sclk_min_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run >= RW'(HALF_CYC)));

    assert_sclk_min_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_run >= RW'(HALF_CYC)));

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    assert_le_sclk_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        le_o |-> !sclk_o);

    assert_le_min_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le_o) |-> (le_run >= RW'(HALF_CYC)));

endmodule

// File: rtl/synprog_seq.sv
// Module: top of the synthesizer programming sequencer. Captures the
// request on start, runs the range check, then drives three words in
// order through the word engine and flags done or err.
// Assumes: start is a strobe; it is acted on only while idle.
module synprog_seq
    import synprog_pkg::*;
#(
    parameter bit WIDE        = 1'b0,
    parameter int CLK_NS      = 8,
    parameter int MIN_HALF_NS = WIDE ? 25 : 50,
    localparam int WORD_W     = WIDE ? 24 : 21,
    localparam int N_W        = WIDE ? 20 : 19,
    localparam int RIN_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_W-1:0]    n_div,
    input  logic [RIN_W-1:0]  r_div,
    input  logic [1:0]        pre_sel,
    input  logic [WORD_W-3:0] cfg_bits,
    input  logic              ld_prec,
    input  logic              cp_gain,
    output logic              sclk,
    output logic              sdata,
    output logic              le,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int HALF_CYC = half_cycles(MIN_HALF_NS, CLK_NS);
    localparam int A_W      = WIDE ? 6 : 5;

    seq_state_e        state;
    logic [N_W-1:0]    n_q;
    logic [RIN_W-1:0]  r_q;
    logic [1:0]        pre_q;
    logic [WORD_W-3:0] cfg_q;
    logic              ld_q;
    logic              gain_q;
    logic [1:0]        idx;
    logic              go;
    logic              fin;
    logic              ok;
    logic [A_W-1:0]    a_cnt;
    logic [B_W-1:0]    b_cnt;
    logic [WORD_W-1:0] word;

    synprog_divsplit #(.WIDE(WIDE), .N_W(N_W), .RIN_W(RIN_W)) u_split (
        .n_i   (n_q),
        .pre_i (pre_q),
        .r_i   (r_q),
        .a_o   (a_cnt),
        .b_o   (b_cnt),
        .ok_o  (ok)
    );

    synprog_wordfmt #(.WIDE(WIDE)) u_fmt (
        .sel_i     (idx),
        .cfg_i     (cfg_q),
        .r_i       (r_q[RF_W-1:0]),
        .ld_prec_i (ld_q),
        .a_i       (a_cnt),
        .b_i       (b_cnt),
        .gain_i    (gain_q),
        .word_o    (word)
    );

    synprog_shifter #(.W(WORD_W), .HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .word_i  (word),
        .sclk_o  (sclk),
        .sdata_o (sdata),
        .le_o    (le),
        .fin_o   (fin)
    );

    // Request capture, range decision and word ordering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            n_q    <= '0;
            r_q    <= '0;
            pre_q  <= '0;
            cfg_q  <= '0;
            ld_q   <= 1'b0;
            gain_q <= 1'b0;
            idx    <= '0;
            go     <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            go <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        n_q    <= n_div;
                        r_q    <= r_div;
                        pre_q  <= pre_sel;
                        cfg_q  <= cfg_bits;
                        ld_q   <= ld_prec;
                        gain_q <= cp_gain;
                        done   <= 1'b0;
                        err    <= 1'b0;
                        busy   <= 1'b1;
                        state  <= SQ_CHECK;
                    end
                end
                SQ_CHECK: begin
                    if (!ok) begin
                        err   <= 1'b1;
                        busy  <= 1'b0;
                        state <= SQ_IDLE;
                    end else begin
                        idx   <= '0;
                        go    <= 1'b1;
                        state <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (fin) begin
                        if (idx == 2'(WORD_CNT - 1)) begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= SQ_IDLE;
                        end else begin
                            idx <= idx + 2'd1;
                            go  <= 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!sclk && !le));

    assert_flags_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(n_q) && $stable(r_q)));

endmodule

// File: tb/tb_synprog_seq.sv
module tb_synprog_seq;

    localparam int HALF = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [18:0] n_div = '0;
    logic [15:0] r_div = '0;
    logic [1:0]  pre_sel = '0;
    logic [18:0] cfg_bits = '0;
    logic        ld_prec = 1'b0;
    logic        cp_gain = 1'b0;
    logic        sclk, sdata, le, busy, done, err;

    always #4 clk = ~clk;

    synprog_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_div(n_div), .r_div(r_div),
        .pre_sel(pre_sel), .cfg_bits(cfg_bits), .ld_prec(ld_prec), .cp_gain(cp_gain),
        .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Serial monitor: bits on sclk rise, words on le rise.
    logic [20:0] mon_sr = '0;
    int          mon_bits = 0;
    int          mon_wc = 0;
    logic [20:0] mon_words [256];

    always @(posedge sclk) begin
        mon_sr = {mon_sr[19:0], sdata};
        mon_bits++;
    end

    always @(posedge le) begin
        mon_words[mon_wc % 256] = mon_sr;
        mon_wc++;
    end

    // Phase width monitor, sampled on the falling clock edge.
    int   min_hi = 1000, min_lo = 1000, min_le = 1000;
    int   run_s = 0, run_le = 0, overlap = 0;
    logic prev_s = 1'b0, prev_le = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk === prev_s) run_s++;
            else begin
                if (prev_s) min_hi = (run_s < min_hi) ? run_s : min_hi;
                else        min_lo = (run_s < min_lo) ? run_s : min_lo;
                run_s = 1;
            end
            if (le === prev_le) run_le++;
            else begin
                if (prev_le) min_le = (run_le < min_le) ? run_le : min_le;
                run_le = 1;
            end
            if (le && sclk) overlap++;
            prev_s  = sclk;
            prev_le = le;
        end
    end

    typedef struct packed {
        logic [18:0] n;
        logic [1:0]  pre;
        logic [15:0] r;
        logic [18:0] cfg;
        logic        ldp;
        logic        gain;
        logic        bad;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{19'd1000,   2'd2, 16'd10,    19'h00094, 1'b1, 1'b1, 1'b0},
        '{19'd1000,   2'd0, 16'd10,    19'h7FFFF, 1'b0, 1'b0, 1'b0},
        '{19'd99,     2'd0, 16'd3,     19'h12345, 1'b1, 1'b0, 1'b0},
        '{19'd262143, 2'd2, 16'd16383, 19'h00000, 1'b0, 1'b1, 1'b0},
        '{19'd24,     2'd0, 16'd200,   19'h55555, 1'b1, 1'b1, 1'b0},
        '{19'd36,     2'd0, 16'd5,     19'h2AAAA, 1'b0, 1'b1, 1'b0},
        '{19'd1000,   2'd2, 16'd2,     19'h00001, 1'b0, 1'b0, 1'b1},
        '{19'd1000,   2'd2, 16'd16384, 19'h00001, 1'b0, 1'b0, 1'b1},
        '{19'd23,     2'd0, 16'd10,    19'h00001, 1'b0, 1'b0, 1'b1},
        '{19'd1000,   2'd1, 16'd10,    19'h00001, 1'b0, 1'b0, 1'b1},
        '{19'd1000,   2'd3, 16'd10,    19'h00001, 1'b0, 1'b0, 1'b1},
        '{19'd101,    2'd2, 16'd10,    19'h00001, 1'b0, 1'b0, 1'b1},
        '{19'd65536,  2'd0, 16'd10,    19'h00001, 1'b0, 1'b0, 1'b1}
    };

    task automatic apply(input vec_t v);
        n_div = v.n; r_div = v.r; pre_sel = v.pre;
        cfg_bits = v.cfg; ld_prec = v.ldp; cp_gain = v.gain;
    endtask

    // Check the three words captured from index wc0 against vector v.
    task automatic check_words(input vec_t v, input int wc0);
        int p, b, a;
        logic [20:0] e0, e1, e2;
        p = 8 << v.pre;
        b = int'(v.n) / p;
        a = int'(v.n) % p;
        e0 = {v.cfg, 2'b10};
        e1 = {v.ldp, 4'b0000, v.r[13:0], 2'b00};
        e2 = {v.gain, 13'(b), 5'(a), 2'b01};
        chk(mon_words[wc0 % 256] == e0, "R1 first word", mon_words[wc0 % 256], e0);
        chk(mon_words[(wc0+1) % 256] == e1, "R4 reference word", mon_words[(wc0+1) % 256], e1);
        chk(mon_words[(wc0+2) % 256] == e2, "R3 main word", mon_words[(wc0+2) % 256], e2);
    endtask

    task automatic run_vec(input vec_t v);
        int wc0, bc0;
        wc0 = mon_wc;
        bc0 = mon_bits;
        @(negedge clk);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", busy, 1);
        chk(done === 1'b0 && err === 1'b0, "R10 flags cleared", {done, err}, 0);
        while (busy) @(negedge clk);
        chk(err === v.bad, "R6 error flag", err, v.bad);
        chk(done === !v.bad, "R1 done flag", done, !v.bad);
        if (v.bad) begin
            chk(mon_bits == bc0, "R6 no sclk edge", mon_bits - bc0, 0);
            chk(mon_wc == wc0, "R6 no le edge", mon_wc - wc0, 0);
        end else begin
            chk(mon_wc - wc0 == 3, "R1 word count", mon_wc - wc0, 3);
            chk(mon_bits - bc0 == 63, "R2 bit count", mon_bits - bc0, 63);
            check_words(v, wc0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure and still summarizes.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of every output.
        chk({sclk, sdata, le, busy, done, err} == 6'b0, "R10 reset outputs",
            {sclk, sdata, le, busy, done, err}, 0);

        // Table walk: R1, R3, R4, R5, R6 across valid and rejected requests.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: a start in mid-transfer with other inputs is ignored.
        begin
            int wc0;
            wc0 = mon_wc;
            @(negedge clk);
            apply(VECS[0]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (100) @(negedge clk);
            apply(VECS[1]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (busy) @(negedge clk);
            chk(mon_wc - wc0 == 3, "R9 words after mid-run start", mon_wc - wc0, 3);
            check_words(VECS[0], wc0);
        end

        // R9: start held into the cycle where the last word completes.
        begin
            int bc0;
            @(negedge clk);
            apply(VECS[2]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!(le && mon_wc % 3 == 0 && busy)) @(negedge clk);
            start = 1'b1;
            while (!done) @(negedge clk);
            start = 1'b0;
            bc0 = mon_bits;
            repeat (60) @(negedge clk);
            chk(mon_bits == bc0, "R9 collision start ignored", mon_bits - bc0, 0);
            chk(done === 1'b1 && busy === 1'b0, "R9 collision flags", {done, busy}, 2'b10);
        end

        // R7 and R8: phase widths and le/sclk separation over the whole run.
        chk(min_hi >= HALF, "R7 sclk high width", min_hi, HALF);
        chk(min_lo >= HALF, "R7 sclk low width", min_lo, HALF);
        chk(min_le >= HALF, "R8 le pulse width", min_le, HALF);
        chk(overlap == 0, "R8 le with sclk high", overlap, 0);

        summary();
        $finish;
    end

endmodule